// File: doc/BRIEF.md
# FSK and DTMF Transmit Tone Synthesizer

This block produces the digital phase of the transmit tones for a low-speed modem front end. It has two 24-bit numerically controlled oscillators, a low-group one and a high-group one, clocked from a 3.579545 MHz master clock. Each oscillator adds a frequency word to its phase on every clock. The top bit of each phase is also brought out as a sign bit. A later sine-shaping stage, outside this block, turns each phase into a waveform.

A two-bit mode input picks the function:
- **FSK:** the low oscillator carries the mark or space frequency. The transmit-data bit chooses between them, within the selected standard and channel.
- **Answer tone:** the low oscillator runs at 2100 Hz.
- **Dual-tone DTMF:** a 4-bit key code sets both oscillators.
- **Single-tone:** one oscillator runs on one group tone of the key, and the other oscillator stays idle.

A change of frequency only changes the increment. The accumulated phase is never reset by it, so FSK keying is phase-continuous. A disable input parks both oscillators at phase zero.

All pins are plain level controls that are sampled on every clock. The outputs are fresh on every clock. There is no streaming handshake and no back-pressure.

Top module: `tone_synth`

## Requirements
- R1: With mode 0 (FSK), `fsk_v23`=0 and `v21_orig`=1, the low oscillator runs at 980 Hz when `tx_data`=1 and at 1180 Hz when `tx_data`=0.
- R2: With mode 0, `fsk_v23`=0 and `v21_orig`=0, the low oscillator runs at 1650 Hz for `tx_data`=1 and at 1850 Hz for `tx_data`=0.
- R3: With mode 0 and `fsk_v23`=1, the low oscillator runs at 1300 Hz for `tx_data`=1 and at 2100 Hz for `tx_data`=0. `v21_orig` has no effect in this case.
- R4: Mode 1 (answer tone) runs the low oscillator at a steady 2100 Hz.
- R5: In mode 2 (dual tone), the low oscillator uses these key codes:
  - 697 Hz for keys 1, 2, 3 and 13.
  - 770 Hz for keys 4, 5, 6 and 14.
  - 852 Hz for keys 7, 8, 9 and 15.
  - 941 Hz for keys 0, 10, 11 and 12.
- R6: In mode 2, the high oscillator uses these key codes:
  - 1209 Hz for keys 1, 4, 7 and 11.
  - 1336 Hz for keys 2, 5, 8 and 10.
  - 1477 Hz for keys 3, 6, 9 and 12.
  - 1633 Hz for keys 0, 13, 14 and 15.
- R7: In mode 3 (single tone), keys 0 to 7 run only the low oscillator, on that key's low-group tone, and the high phase stays 0. Keys 8 to 15 run only the high oscillator, on that key's high-group tone, and the low phase stays 0.
- R8: In modes 0 and 1, the high oscillator phase stays 0.
- R9: `tx_off`=1 forces both phases to 0 and `active` to 0 at the next clock edge. `tx_off`=0 sets `active` to 1 at the next clock edge.
- R10: Each frequency word is round(f × 2^24 / 3579545). Every per-clock phase step, and every measured tone period, matches the nominal frequency within 0.1%.
- R11: A change of frequency only changes the increment. The phase after the change equals the phase before it plus the new word.
- R12: While reset is held, both phases are 0 and `active` is 0.
- R13: `lo_sign` and `hi_sign` equal bit 23 of their phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 3.579545 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 FSK, 1 answer tone, 2 dual DTMF, 3 single DTMF |
| fsk_v23 | input | 1 | 1 selects 1200-baud FSK frequencies, 0 selects 300-baud |
| v21_orig | input | 1 | 300-baud channel: 1 originate, 0 answer |
| tx_data | input | 1 | FSK bit: 1 mark, 0 space |
| key | input | 4 | DTMF key code |
| tx_off | input | 1 | 1 disables both oscillators |
| lo_phase | output | 24 | Low-group oscillator phase |
| lo_sign | output | 1 | Top bit of the low phase |
| hi_phase | output | 24 | High-group oscillator phase |
| hi_sign | output | 1 | Top bit of the high phase |
| active | output | 1 | Tone output enabled |

## Verification
Two events can fall in the same clock cycle:
- A mark/space change of `tx_data`.
- An assertion of `tx_off`.

The bench drives both on the same falling edge while FSK is running. On the next edge, disable must win: both phases are zero and `active` is low. A separate directed test toggles `tx_data` alone and checks that the phase steps by exactly the new word, with no jump.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    MODE_FSK    = 2'd0,
    MODE_ANSWER = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_SINGLE = 2'd3
  } tone_mode_e;

  // Rounded phase increment for a tone of hz at clock clk_hz, acc_w-bit phase.
  function automatic longint unsigned tone_word(input longint unsigned hz,
                                                input longint unsigned clk_hz,
                                                input int unsigned acc_w);
    longint unsigned scale;
    scale = 64'd1 << acc_w;
    return (hz * scale + clk_hz / 2) / clk_hz;
  endfunction
endpackage

// File: rtl/tone_dtmf_map.sv
module tone_dtmf_map #(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 3579545
) (
  input  logic [3:0]       key,
  output logic [ACC_W-1:0] lo_word,
  output logic [ACC_W-1:0] hi_word
);
  import tone_pkg::*;

  localparam logic [ACC_W-1:0] W697  = ACC_W'(tone_word(697,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W770  = ACC_W'(tone_word(770,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W852  = ACC_W'(tone_word(852,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W941  = ACC_W'(tone_word(941,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W1209 = ACC_W'(tone_word(1209, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W1336 = ACC_W'(tone_word(1336, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W1477 = ACC_W'(tone_word(1477, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W1633 = ACC_W'(tone_word(1633, CLK_HZ, ACC_W));

  always_comb begin
    case (key)
      4'd1, 4'd2, 4'd3, 4'd13: lo_word = W697;
      4'd4, 4'd5, 4'd6, 4'd14: lo_word = W770;
      4'd7, 4'd8, 4'd9, 4'd15: lo_word = W852;
      default:                 lo_word = W941;
    endcase
  end

  always_comb begin
    case (key)
      4'd1, 4'd4, 4'd7, 4'd11: hi_word = W1209;
      4'd2, 4'd5, 4'd8, 4'd10: hi_word = W1336;
      4'd3, 4'd6, 4'd9, 4'd12: hi_word = W1477;
      default:                 hi_word = W1633;
    endcase
  end
endmodule

// File: rtl/tone_freq_sel.sv
module tone_freq_sel #(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 3579545
) (
  input  logic [1:0]       mode,
  input  logic             fsk_v23,
  input  logic             v21_orig,
  input  logic             tx_data,
  input  logic [3:0]       key,
  input  logic             tx_off,
  output logic [ACC_W-1:0] inc_lo,
  output logic [ACC_W-1:0] inc_hi,
  output logic             run_lo,
  output logic             run_hi
);
  import tone_pkg::*;

  localparam logic [ACC_W-1:0] W_ORG_MARK  = ACC_W'(tone_word(980,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W_ORG_SPACE = ACC_W'(tone_word(1180, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W_ANS_MARK  = ACC_W'(tone_word(1650, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W_ANS_SPACE = ACC_W'(tone_word(1850, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W_HS_MARK   = ACC_W'(tone_word(1300, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] W_2100      = ACC_W'(tone_word(2100, CLK_HZ, ACC_W));

  logic [ACC_W-1:0] key_lo, key_hi, fsk_word;
  tone_mode_e       sel;

  tone_dtmf_map #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_map (
    .key(key), .lo_word(key_lo), .hi_word(key_hi)
  );

  assign sel = tone_mode_e'(mode);

  always_comb begin
    if (fsk_v23)       fsk_word = tx_data ? W_HS_MARK  : W_2100;
    else if (v21_orig) fsk_word = tx_data ? W_ORG_MARK : W_ORG_SPACE;
    else               fsk_word = tx_data ? W_ANS_MARK : W_ANS_SPACE;
  end

  always_comb begin
    inc_lo = '0;
    inc_hi = '0;
    run_lo = 1'b0;
    run_hi = 1'b0;
    case (sel)
      MODE_FSK:    begin run_lo = 1'b1; inc_lo = fsk_word; end
      MODE_ANSWER: begin run_lo = 1'b1; inc_lo = W_2100; end
      MODE_DUAL:   begin
        run_lo = 1'b1; inc_lo = key_lo;
        run_hi = 1'b1; inc_hi = key_hi;
      end
      MODE_SINGLE: begin
        run_lo = ~key[3]; inc_lo = key_lo;
        run_hi =  key[3]; inc_hi = key_hi;
      end
      default: ;
    endcase
    if (tx_off) begin
      run_lo = 1'b0;
      run_hi = 1'b0;
    end
  end
endmodule

// File: rtl/tone_nco.sv
module tone_nco #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase
);
  // The increment may change on any clock; the accumulated phase is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (run) phase <= phase + inc;
    else          phase <= '0;
  end
endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 3579545
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             fsk_v23,
  input  logic             v21_orig,
  input  logic             tx_data,
  input  logic [3:0]       key,
  input  logic             tx_off,
  output logic [ACC_W-1:0] lo_phase,
  output logic             lo_sign,
  output logic [ACC_W-1:0] hi_phase,
  output logic             hi_sign,
  output logic             active
);
  localparam int N_OSC = 2;

  logic [ACC_W-1:0] inc_a   [N_OSC];
  logic [ACC_W-1:0] phase_a [N_OSC];
  logic             run_a   [N_OSC];

  tone_freq_sel #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_sel (
    .mode(mode), .fsk_v23(fsk_v23), .v21_orig(v21_orig), .tx_data(tx_data),
    .key(key), .tx_off(tx_off),
    .inc_lo(inc_a[0]), .inc_hi(inc_a[1]), .run_lo(run_a[0]), .run_hi(run_a[1])
  );

  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    tone_nco #(.ACC_W(ACC_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .run(run_a[i]), .inc(inc_a[i]), .phase(phase_a[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= ~tx_off;
  end

  assign lo_phase = phase_a[0];
  assign hi_phase = phase_a[1];
  assign lo_sign  = phase_a[0][ACC_W-1];
  assign hi_sign  = phase_a[1][ACC_W-1];
endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk #(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 3579545
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             fsk_v23,
  input logic             v21_orig,
  input logic             tx_data,
  input logic [3:0]       key,
  input logic             tx_off,
  input logic [ACC_W-1:0] lo_phase,
  input logic [ACC_W-1:0] hi_phase,
  input logic             active
);
  import tone_pkg::*;

  localparam logic [ACC_W-1:0] C980  = ACC_W'(tone_word(980,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] C1180 = ACC_W'(tone_word(1180, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] C1650 = ACC_W'(tone_word(1650, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] C1850 = ACC_W'(tone_word(1850, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] C1300 = ACC_W'(tone_word(1300, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] C2100 = ACC_W'(tone_word(2100, CLK_HZ, ACC_W));

  logic [ACC_W-1:0] want_fsk;
  always_comb begin
    case ({fsk_v23, v21_orig, tx_data})
      3'b011:         want_fsk = C980;
      3'b010:         want_fsk = C1180;
      3'b001:         want_fsk = C1650;
      3'b000:         want_fsk = C1850;
      3'b101, 3'b111: want_fsk = C1300;
      default:        want_fsk = C2100;
    endcase
  end

  // R11: FSK phase advances by exactly the selected word, even across a mark/space change
  assert_fsk_continuous_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !tx_off) |=> lo_phase == ACC_W'($past(lo_phase) + $past(want_fsk)));

  assert_answer_tone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !tx_off) |=> lo_phase == ACC_W'($past(lo_phase) + C2100));

  assert_hi_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd1) |=> hi_phase == '0);

  assert_single_one_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && key[3]) |=> lo_phase == '0);

  assert_single_lo_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !key[3]) |=> hi_phase == '0);

  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off |=> (lo_phase == '0 && hi_phase == '0 && !active));

  assert_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_off |=> active);
endmodule

bind tone_synth tone_synth_chk #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .fsk_v23(fsk_v23), .v21_orig(v21_orig),
  .tx_data(tx_data), .key(key), .tx_off(tx_off), .lo_phase(lo_phase),
  .hi_phase(hi_phase), .active(active)
);

// File: tb/tone_synth_tb.sv
module tone_synth_tb;
  localparam int  CLK_PERIOD = 280;
  localparam longint CLK_HZ  = 3579545;
  localparam longint SCALE   = 64'd16777216;
  localparam int  NV = 31;

  // {mode, v23, orig, txd, key, lo_hz, hi_hz}; 0 Hz means idle oscillator
  localparam logic [32:0] VEC [NV] = '{
    {2'd0,1'b0,1'b1,1'b1,4'd0,12'd980, 12'd0},
    {2'd0,1'b0,1'b1,1'b0,4'd0,12'd1180,12'd0},
    {2'd0,1'b0,1'b0,1'b1,4'd0,12'd1650,12'd0},
    {2'd0,1'b0,1'b0,1'b0,4'd0,12'd1850,12'd0},
    {2'd0,1'b1,1'b1,1'b1,4'd0,12'd1300,12'd0},
    {2'd0,1'b1,1'b0,1'b0,4'd0,12'd2100,12'd0},
    {2'd1,1'b0,1'b0,1'b0,4'd5,12'd2100,12'd0},
    {2'd2,1'b0,1'b0,1'b0,4'd0, 12'd941,12'd1633},
    {2'd2,1'b0,1'b0,1'b0,4'd1, 12'd697,12'd1209},
    {2'd2,1'b0,1'b0,1'b0,4'd2, 12'd697,12'd1336},
    {2'd2,1'b0,1'b0,1'b0,4'd3, 12'd697,12'd1477},
    {2'd2,1'b0,1'b0,1'b0,4'd4, 12'd770,12'd1209},
    {2'd2,1'b0,1'b0,1'b0,4'd5, 12'd770,12'd1336},
    {2'd2,1'b0,1'b0,1'b0,4'd6, 12'd770,12'd1477},
    {2'd2,1'b0,1'b0,1'b0,4'd7, 12'd852,12'd1209},
    {2'd2,1'b0,1'b0,1'b0,4'd8, 12'd852,12'd1336},
    {2'd2,1'b0,1'b0,1'b0,4'd9, 12'd852,12'd1477},
    {2'd2,1'b0,1'b0,1'b0,4'd10,12'd941,12'd1336},
    {2'd2,1'b0,1'b0,1'b0,4'd11,12'd941,12'd1209},
    {2'd2,1'b0,1'b0,1'b0,4'd12,12'd941,12'd1477},
    {2'd2,1'b0,1'b0,1'b0,4'd13,12'd697,12'd1633},
    {2'd2,1'b0,1'b0,1'b0,4'd14,12'd770,12'd1633},
    {2'd2,1'b0,1'b0,1'b0,4'd15,12'd852,12'd1633},
    {2'd3,1'b0,1'b0,1'b0,4'd0, 12'd941,12'd0},
    {2'd3,1'b0,1'b0,1'b0,4'd3, 12'd697,12'd0},
    {2'd3,1'b0,1'b0,1'b0,4'd5, 12'd770,12'd0},
    {2'd3,1'b0,1'b0,1'b0,4'd7, 12'd852,12'd0},
    {2'd3,1'b0,1'b0,1'b0,4'd8, 12'd0,  12'd1336},
    {2'd3,1'b0,1'b0,1'b0,4'd11,12'd0,  12'd1209},
    {2'd3,1'b0,1'b0,1'b0,4'd13,12'd0,  12'd1633},
    {2'd3,1'b0,1'b0,1'b0,4'd15,12'd0,  12'd1633}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic fsk_v23 = 1'b0, v21_orig = 1'b1, tx_data = 1'b1, tx_off = 1'b0;
  logic [3:0] key = 4'd0;
  logic [23:0] lo_phase, hi_phase;
  logic lo_sign, hi_sign, active;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_synth u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fsk_v23(fsk_v23), .v21_orig(v21_orig),
    .tx_data(tx_data), .key(key), .tx_off(tx_off), .lo_phase(lo_phase),
    .lo_sign(lo_sign), .hi_phase(hi_phase), .hi_sign(hi_sign), .active(active)
  );

  function automatic longint exp_word(input longint hz);
    return (hz * SCALE + CLK_HZ / 2) / CLK_HZ;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Step and 0.1% checks on one oscillator over two consecutive samples
  task automatic check_osc(input string req, input longint hz,
                           input logic [23:0] p0, input logic [23:0] p1, input logic sg);
    longint d, err, ref_v;
    d = longint'(24'(p1 - p0));
    if (hz == 0) begin
      check(p0 == 0 && p1 == 0, req, longint'(p1), 0);
    end else begin
      check(d == exp_word(hz), req, d, exp_word(hz));
      ref_v = hz * SCALE;
      err = d * CLK_HZ - ref_v;
      if (err < 0) err = -err;
      check(err * 1000 <= ref_v, "R10", d, exp_word(hz));
      check(sg == p1[23], "R13", longint'(sg), longint'(p1[23]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] a0, a1, b0, b1;
    logic al, bl;
    string rq_lo, rq_hi;

    // R12: reset state
    repeat (3) @(negedge clk);
    check(lo_phase == 0 && hi_phase == 0, "R12", longint'(lo_phase | hi_phase), 0);
    check(active == 1'b0, "R12", longint'(active), 0);
    rst_n = 1'b1;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {mode, fsk_v23, v21_orig, tx_data, key} = VEC[v][32:24];
      repeat (3) @(negedge clk);
      a0 = lo_phase; b0 = hi_phase;
      @(negedge clk);
      a1 = lo_phase; b1 = hi_phase; al = lo_sign; bl = hi_sign;
      case (mode)
        2'd0: begin rq_lo = fsk_v23 ? "R3" : (v21_orig ? "R1" : "R2"); rq_hi = "R8"; end
        2'd1: begin rq_lo = "R4"; rq_hi = "R8"; end
        2'd2: begin rq_lo = "R5"; rq_hi = "R6"; end
        default: begin rq_lo = "R7"; rq_hi = "R7"; end
      endcase
      check_osc(rq_lo, longint'(VEC[v][23:12]), a0, a1, al);
      check_osc(rq_hi, longint'(VEC[v][11:0]),  b0, b1, bl);
    end

    // R3: originate/answer select has no effect at 1200 baud
    @(negedge clk);
    mode = 2'd0; fsk_v23 = 1'b1; v21_orig = 1'b0; tx_data = 1'b1;
    repeat (2) @(negedge clk);
    a0 = lo_phase; @(negedge clk); a1 = lo_phase;
    check(24'(a1 - a0) == 24'(exp_word(1300)), "R3", longint'(24'(a1 - a0)), exp_word(1300));

    // R11: mark to space switch keeps phase, adds new word
    fsk_v23 = 1'b0; v21_orig = 1'b1; tx_data = 1'b1;
    repeat (5) @(negedge clk);
    a0 = lo_phase;
    tx_data = 1'b0;
    @(negedge clk);
    a1 = lo_phase;
    check(a1 == 24'(a0 + 24'(exp_word(1180))), "R11", longint'(a1), longint'(24'(a0 + 24'(exp_word(1180)))));
    tx_data = 1'b1;
    @(negedge clk);
    check(lo_phase == 24'(a1 + 24'(exp_word(980))), "R11", longint'(lo_phase), longint'(24'(a1 + 24'(exp_word(980)))));

    // R9: data change and disable in the same cycle; disable wins
    tx_data = 1'b0; tx_off = 1'b1;
    @(negedge clk);
    check(lo_phase == 0 && hi_phase == 0, "R9", longint'(lo_phase), 0);
    check(active == 1'b0, "R9", longint'(active), 0);
    tx_off = 1'b0;
    @(negedge clk);
    check(active == 1'b1, "R9", longint'(active), 1);
    check(lo_phase == 24'(exp_word(1180)), "R9", longint'(lo_phase), exp_word(1180));

    // R10: measured period of the 941 Hz low tone, key 0 dual mode
    mode = 2'd2; key = 4'd0; tx_off = 1'b1;
    @(negedge clk);
    tx_off = 1'b0;
    begin
      int cyc = 0, edges = 0;
      logic prev = 1'b0;
      longint e;
      while (edges < 2 && cyc < 20000) begin
        @(negedge clk);
        if (edges == 1) cyc++;
        if (lo_sign && !prev) edges++;
        prev = lo_sign;
      end
      e = longint'(cyc) * 941 - CLK_HZ;
      if (e < 0) e = -e;
      check(e * 1000 <= CLK_HZ, "R10", longint'(cyc), CLK_HZ / 941);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule